// File: doc/BRIEF.md
# Unrolled AES-128 Block Encryptor

This block encrypts 128-bit data blocks under 128-bit keys with the AES-128 cipher. All ten cipher rounds are laid out in hardware, one after another, with a register stage behind each one and behind the opening key addition. A new plaintext/key pair may be presented on every clock, and up to eleven blocks are in flight at the same time.

The round keys are not stored anywhere. Each stage derives its round key from the key that the previous stage registered, so every block carries its own key down the pipeline. Back-to-back blocks may therefore use different keys with no penalty. A valid bit travels with each block. Gaps in the input stream show up as the same gaps at the output, eleven clocks later.

Top module: `aes128_pipe_enc`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every valid bit in the pipeline is cleared. Blocks presented during reset never appear at the output, and `out_valid` stays low after reset until a block accepted afterwards arrives.
- R2: A block accepted with `in_valid` high at rising edge N is presented with `out_valid` high in the interval that follows rising edge N+10, which is eleven register stages. Exactly one output is produced per accepted block.
- R3: Bytes enter the state column by column, with byte 0 of a block or key in bits 127:120. Plaintext 00112233445566778899aabbccddeeff under key 000102030405060708090a0b0c0d0e0f yields 69c4e0d86a7b0430d8cdb78070b4c55a.
- R4: For any plaintext and key, `out_block` equals the AES-128 encryption: an initial key XOR, nine rounds of byte substitution, row rotation, column mixing and key XOR, and a final round without column mixing.
- R5: Blocks may be accepted on consecutive clocks, each with a different key, and each result uses its own key only.
- R6: Round key k is formed from round key k-1 by rotating its last word one byte left, substituting its bytes, XORing the first byte with the round constant (01, 02, 04, 08, 10, 20, 40, 80, 1b, 36 for rounds 1 to 10), and chaining the words by XOR.
- R7: Column mixing multiplies each column by the circulant {02},{03},{01},{01} in GF(2^8) modulo x^8+x^4+x^3+x+1. As a consequence, the XOR of a column's four bytes is the same before and after mixing.
- R8: A reset asserted while blocks are in flight discards all of them, and blocks accepted after reset are processed normally.
- R9: A clock with `in_valid` low produces a clock with `out_valid` low eleven stages later, with no effect on neighbouring blocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the valid bits |
| in_valid | input | 1 | A plaintext/key pair is presented this cycle |
| in_block | input | 128 | Plaintext block, byte 0 in the top bits |
| in_key | input | 128 | Cipher key for this block, byte 0 in the top bits |
| out_valid | output | 1 | `out_block` holds a finished ciphertext |
| out_block | output | 128 | Ciphertext block, byte 0 in the top bits |

## Verification
On every cycle, the assertions check three things. The count of occupied stages never exceeds eleven and is non-zero whenever a result is offered. Each registered round key satisfies the word-chaining relation against the key of the stage before it. Every mixed column keeps the XOR of its bytes. Only the bench's scenarios can show that the ciphertext values are correct: the known vector, random blocks with random gaps, a back-to-back stream with a fresh key per block, and a reset in the middle of a stream. Each of these is compared cycle by cycle against a behavioural model that computes the cipher from byte arrays.

// File: rtl/aes128_pkg.sv
`timescale 1ns/1ps
// aes128_pkg: widths, types and GF(2^8) helper functions shared by the
// encryptor stages. Assumes byte 0 of a block sits in the top bits.
package aes128_pkg;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int BLK_BYTES  = 16;
    localparam int WORD_W     = WORD_BYTES * BYTE_W;
    localparam int BLK_W      = BLK_BYTES * BYTE_W;
    localparam int COLS       = BLK_BYTES / WORD_BYTES;

    typedef logic [BYTE_W-1:0] gf_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BLK_W-1:0]  blk_t;

    // Multiply by x modulo x^8+x^4+x^3+x+1.
    function automatic gf_t gf_xtime(gf_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // Shift-and-add product in GF(2^8).
    function automatic gf_t gf_mul(gf_t a, gf_t b);
        gf_t acc;
        gf_t p;
        acc = '0;
        p   = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ p;
            p = gf_xtime(p);
        end
        return acc;
    endfunction

    // Inverse as a^254 (maps 0 to 0).
    function automatic gf_t gf_inv(gf_t a);
        gf_t r;
        gf_t p;
        r = 8'h01;
        p = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (i != 0) r = gf_mul(r, p);
            p = gf_mul(p, p);
        end
        return r;
    endfunction

    // Substitution: field inverse followed by the affine map.
    function automatic gf_t sub_byte(gf_t a);
        gf_t v;
        v = gf_inv(a);
        return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
                 ^ {v[3:0], v[7:4]} ^ 8'h63;
    endfunction

    // Round constant for round n (n starts at 1).
    function automatic gf_t round_const(int n);
        gf_t r;
        r = 8'h01;
        for (int i = 1; i < n; i++) r = gf_xtime(r);
        return r;
    endfunction

    // XOR of the four bytes of a column.
    function automatic gf_t col_parity(word_t w);
        return w[31:24] ^ w[23:16] ^ w[15:8] ^ w[7:0];
    endfunction
endpackage

// File: rtl/aes128_keystep.sv
`timescale 1ns/1ps
// aes128_keystep: combinational derivation of the next round key from the
// current one. RCON is the constant of the round being produced.
// Assumes word 0 of the key occupies the top 32 bits.
module aes128_keystep
    import aes128_pkg::*;
#(
    parameter gf_t RCON = 8'h01
) (
    input  blk_t rk_in,
    output blk_t rk_next
);
    word_t w0, w1, w2, w3, rot, mix_word;
    word_t n0, n1, n2, n3;

    // Split the key into words, rotate and substitute the last, then chain.
    always_comb begin
        {w0, w1, w2, w3} = rk_in;
        rot      = {w3[WORD_W-BYTE_W-1:0], w3[WORD_W-1:WORD_W-BYTE_W]};
        mix_word = {sub_byte(rot[31:24]), sub_byte(rot[23:16]),
                    sub_byte(rot[15:8]),  sub_byte(rot[7:0])};
        mix_word = mix_word ^ {RCON, {(WORD_W-BYTE_W){1'b0}}};
        n0 = w0 ^ mix_word;
        n1 = w1 ^ n0;
        n2 = w2 ^ n1;
        n3 = w3 ^ n2;
        rk_next = {n0, n1, n2, n3};
    end
endmodule

// File: rtl/aes128_round.sv
`timescale 1ns/1ps
// aes128_round: one registered cipher round (substitute, rotate rows,
// mix columns unless FINAL, add round key). The valid bit is reset;
// the state register is not. Assumes column-major byte order, byte 0 on top.
module aes128_round
    import aes128_pkg::*;
#(
    parameter bit FINAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic v_in,
    input  blk_t st_in,
    input  blk_t rk,
    output logic v_q,
    output blk_t st_q
);
    gf_t  sub_b [BLK_BYTES];
    gf_t  sh_b  [BLK_BYTES];
    blk_t mixed;

    // Byte substitution and row rotation: row r reads column (c+r) mod 4.
    for (genvar i = 0; i < BLK_BYTES; i++) begin : g_sub
        assign sub_b[i] = sub_byte(st_in[BLK_W-1-BYTE_W*i -: BYTE_W]);
    end
    for (genvar c = 0; c < COLS; c++) begin : g_col
        for (genvar r = 0; r < WORD_BYTES; r++) begin : g_row
            assign sh_b[WORD_BYTES*c+r] = sub_b[WORD_BYTES*((c+r)%COLS)+r];
        end

        word_t col_in;
        assign col_in = {sh_b[4*c], sh_b[4*c+1], sh_b[4*c+2], sh_b[4*c+3]};

        if (FINAL) begin : g_pass
            assign mixed[BLK_W-1-WORD_W*c -: WORD_W] = col_in;
        end else begin : g_mix
            gf_t a0, a1, a2, a3;
            assign {a0, a1, a2, a3} = col_in;
            assign mixed[BLK_W-1-WORD_W*c -: WORD_W] = {
                gf_xtime(a0) ^ gf_xtime(a1) ^ a1 ^ a2 ^ a3,
                a0 ^ gf_xtime(a1) ^ gf_xtime(a2) ^ a2 ^ a3,
                a0 ^ a1 ^ gf_xtime(a2) ^ gf_xtime(a3) ^ a3,
                gf_xtime(a0) ^ a0 ^ a1 ^ a2 ^ gf_xtime(a3)};

            // R7: the matrix coefficients XOR to 1, so column parity survives.
            a_r7_mix_col_parity: assert property (@(posedge clk) disable iff (!rst_n)
                v_in |-> col_parity(mixed[BLK_W-1-WORD_W*c -: WORD_W]) == col_parity(col_in));
        end
    end

    // Valid bit of this stage, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) v_q <= 1'b0;
        else        v_q <= v_in;
    end

    // State register of this stage, loaded every clock with the keyed result.
    always_ff @(posedge clk) begin
        st_q <= mixed ^ rk;
    end
endmodule

// File: rtl/aes128_pipe_enc.sv
`timescale 1ns/1ps
// aes128_pipe_enc: fully unrolled AES-128 encryptor. The input stage adds the
// key, then ROUNDS registered rounds follow, each paired with a key step, so
// one block per clock enters and each block carries its own key.
// Assumes ROUNDS = 10 for AES-128; latency is ROUNDS+1 clocks.
module aes128_pipe_enc
    import aes128_pkg::*;
#(
    parameter int ROUNDS = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [127:0] in_block,
    input  logic [127:0] in_key,
    output logic         out_valid,
    output logic [127:0] out_block
);
    localparam int LATENCY = ROUNDS + 1;
    localparam int OCC_W   = $clog2(LATENCY + 1);

    logic v_p   [0:ROUNDS];
    blk_t st_p  [0:ROUNDS];
    blk_t key_p [0:ROUNDS-1];

    logic v0_q;
    blk_t st0_q, key0_q;

    // Input stage valid bit, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) v0_q <= 1'b0;
        else        v0_q <= in_valid;
    end

    // Input stage data: initial key addition and the key kept for expansion.
    always_ff @(posedge clk) begin
        st0_q  <= in_block ^ in_key;
        key0_q <= in_key;
    end

    assign v_p[0]   = v0_q;
    assign st_p[0]  = st0_q;
    assign key_p[0] = key0_q;

    for (genvar k = 1; k <= ROUNDS; k++) begin : g_stage
        blk_t rk_n;

        aes128_keystep #(.RCON(round_const(k))) u_key (
            .rk_in   (key_p[k-1]),
            .rk_next (rk_n)
        );

        aes128_round #(.FINAL(k == ROUNDS)) u_rnd (
            .clk   (clk),
            .rst_n (rst_n),
            .v_in  (v_p[k-1]),
            .st_in (st_p[k-1]),
            .rk    (rk_n),
            .v_q   (v_p[k]),
            .st_q  (st_p[k])
        );

        if (k < ROUNDS) begin : g_keyreg
            blk_t key_r;
            // Round key register travelling beside the data of this stage.
            always_ff @(posedge clk) begin
                key_r <= rk_n;
            end
            assign key_p[k] = key_r;

            // R6: last two words of a round key XOR to the previous key's last word.
            a_r6_key_chain: assert property (@(posedge clk) disable iff (!rst_n)
                v_p[k-1] |=> ((key_r[WORD_W-1:0] ^ key_r[2*WORD_W-1:WORD_W])
                              == $past(key_p[k-1][WORD_W-1:0])));
        end
    end

    assign out_valid = v_p[ROUNDS];
    assign out_block = st_p[ROUNDS];

    // Occupancy of the valid chain, used only by the assertions below.
    logic [OCC_W-1:0] occ_q;
    always_ff @(posedge clk) begin
        if (!rst_n) occ_q <= '0;
        else        occ_q <= occ_q + OCC_W'(in_valid) - OCC_W'(out_valid);
    end

    // R2: never more blocks in flight than register stages.
    a_r2_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= OCC_W'(LATENCY));

    // R2: no result appears without an accepted block behind it.
    a_r2_out_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> occ_q != '0);
endmodule

// File: tb/aes128_pipe_enc_bench.sv
`timescale 1ns/1ps
// Bench: behavioural AES-128 model on byte arrays, a queue as the delay
// line of expected results, compared at every falling edge.
module aes128_pipe_enc_bench;
    localparam int LAT = 11;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [127:0] in_block, in_key;
    logic         out_valid;
    logic [127:0] out_block;

    aes128_pipe_enc u_aes128_pipe_enc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_block(in_block),
        .in_key(in_key), .out_valid(out_valid), .out_block(out_block)
    );

    always #2 clk = ~clk;

    typedef struct {
        bit           v;
        logic [127:0] ct;
        string        tag;
    } exp_t;

    exp_t  q[$];
    int    checks = 0;
    int    errors = 0;
    bit    seen_rst = 0;
    bit    done = 0;
    string vtag = "R1";
    string dtag = "R4";
    logic [7:0] sb [256];

    function automatic logic [7:0] gm(logic [7:0] a, logic [7:0] b);
        logic [7:0] r = 0;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
        end
        return r;
    endfunction

    // Substitution table by exhaustive inverse search and a bitwise affine map.
    initial begin
        for (int a = 0; a < 256; a++) begin
            logic [7:0] inv = 0;
            logic [7:0] s;
            for (int b = 1; b < 256; b++) if (gm(a[7:0], b[7:0]) == 8'h01) inv = b[7:0];
            for (int i = 0; i < 8; i++)
                s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8]
                       ^ ((8'h63 >> i) & 1'b1);
            sb[a] = s;
        end
    end

    function automatic logic [127:0] ref_enc(logic [127:0] pt, logic [127:0] key);
        logic [7:0] w [176];
        logic [7:0] s [16];
        logic [7:0] t [16];
        logic [7:0] tw [4];
        logic [7:0] rc = 8'h01;
        logic [127:0] res;
        for (int j = 0; j < 16; j++) w[j] = key[127-8*j -: 8];
        for (int i = 4; i < 44; i++) begin
            for (int j = 0; j < 4; j++) tw[j] = w[4*(i-1)+j];
            if (i % 4 == 0) begin
                logic [7:0] f = tw[0];
                tw[0] = sb[tw[1]] ^ rc; tw[1] = sb[tw[2]]; tw[2] = sb[tw[3]]; tw[3] = sb[f];
                rc = gm(rc, 8'h02);
            end
            for (int j = 0; j < 4; j++) w[4*i+j] = w[4*(i-4)+j] ^ tw[j];
        end
        for (int j = 0; j < 16; j++) s[j] = pt[127-8*j -: 8] ^ w[j];
        for (int r = 1; r <= 10; r++) begin
            for (int c = 0; c < 4; c++)
                for (int rw = 0; rw < 4; rw++) t[4*c+rw] = sb[s[4*((c+rw)%4)+rw]];
            for (int c = 0; c < 4; c++) begin
                logic [7:0] a0 = t[4*c], a1 = t[4*c+1], a2 = t[4*c+2], a3 = t[4*c+3];
                if (r < 10) begin
                    t[4*c]   = gm(a0, 2) ^ gm(a1, 3) ^ a2 ^ a3;
                    t[4*c+1] = a0 ^ gm(a1, 2) ^ gm(a2, 3) ^ a3;
                    t[4*c+2] = a0 ^ a1 ^ gm(a2, 2) ^ gm(a3, 3);
                    t[4*c+3] = gm(a0, 3) ^ a1 ^ a2 ^ gm(a3, 2);
                end
            end
            for (int j = 0; j < 16; j++) s[j] = t[j] ^ w[16*r+j];
        end
        for (int j = 0; j < 16; j++) res[127-8*j -: 8] = s[j];
        return res;
    endfunction

    // Delay line of expected outputs; a reset edge voids everything in flight.
    always @(posedge clk) begin : p_model
        exp_t e;
        if (!rst_n) begin
            seen_rst = 1;
            for (int i = 0; i < q.size(); i++) q[i].v = 1'b0;
        end
        e.v   = rst_n && in_valid;
        e.ct  = e.v ? ref_enc(in_block, in_key) : '0;
        e.tag = dtag;
        q.push_back(e);
        if (q.size() > LAT) void'(q.pop_front());
    end

    // Compare at the falling edge, away from the register updates.
    always @(negedge clk) begin : p_cmp
        bit           ev;
        logic [127:0] ec;
        string        et;
        if (seen_rst && !done) begin
            ev = 0; ec = '0; et = dtag;
            if (q.size() == LAT) begin ev = q[0].v; ec = q[0].ct; et = q[0].tag; end
            checks++;
            if (out_valid !== ev) begin
                errors++;
                $display("FAIL %s: out_valid=%0b expected %0b", vtag, out_valid, ev);
            end
            if (ev) begin
                checks++;
                if (out_block !== ec) begin
                    errors++;
                    $display("FAIL %s: out_block=%h expected %h", et, out_block, ec);
                end
            end
        end
    end

    task automatic drive(bit v, logic [127:0] pt, logic [127:0] k);
        @(negedge clk);
        in_valid = v; in_block = pt; in_key = k;
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin : p_main
        rst_n = 0; in_valid = 1; in_block = rnd128(); in_key = rnd128();
        // R1: blocks offered during reset must never emerge.
        repeat (4) @(negedge clk);
        rst_n = 1; in_valid = 0;
        repeat (14) drive(0, '0, '0);
        // R3: known vector and byte order.
        vtag = "R2"; dtag = "R3";
        drive(1, 128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f);
        repeat (12) drive(0, '0, '0);
        // R4, R6, R7, R9: random blocks and keys with random gaps.
        vtag = "R2,R9"; dtag = "R4,R6,R7";
        for (int i = 0; i < 80; i++) drive($urandom_range(0, 1) == 1, rnd128(), rnd128());
        // R5: a new block with a fresh key on every clock.
        vtag = "R2,R5"; dtag = "R5";
        for (int i = 0; i < 40; i++) drive(1, rnd128(), rnd128());
        // R8: reset in the middle of a stream, then resume.
        vtag = "R8"; dtag = "R8";
        for (int i = 0; i < 6; i++) drive(1, rnd128(), rnd128());
        @(negedge clk); rst_n = 0; in_valid = 1;
        @(negedge clk); rst_n = 1;
        for (int i = 0; i < 5; i++) drive(1, rnd128(), rnd128());
        repeat (15) drive(0, '0, '0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : p_watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: run still busy (actual hung, expected finished)");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule